// File: doc/BRIEF.md
# Selectable 8 kHz Frame Reference Generator

This block makes the 8 kHz strobes that pace framing logic. It also makes a one-second strobe from them. All activity is synchronous to one system clock. Each line-rate clock is presented as a one-cycle enable pulse on that clock. A divider turns the chosen line-rate enable stream into an 8 kHz strobe. Its modulus depends on the line rate: 6480 for a 51.84 MHz source, 5592 for a DS3-rate source and 4296 for an E3-rate source.

There are three layers of selection. A port reference is taken from one of three places: a receive-path 8 kHz strobe, the divided transmit clock, or the divided receive clock. The port divider's modulus comes from the port's line mode. The global reference is taken from one of three places: an external 8 kHz input, a divided line-rate source, or the port reference. The transmit-path reference follows either the global reference or the port reference. The one-second strobe counts global strobes. All configuration inputs are treated as static settings. Changing one restarts the divider it affects.

Top module: `frame_ref_gen`

## Requirements
- R1: When `cfg_glb_ext`=0 and `cfg_glb_sel` is 0, 1 or 2, the global divider counts only the enable of the selected source: 0 = `src_oc1_en` with modulus CC52_DIV, 1 = `src_ds3_en` with modulus DS3_DIV, 2 = `src_e3_en` with modulus E3_DIV. `glb_ref` is high for exactly one cycle, in the cycle after every modulus-th counted enable. All other source enables have no effect on it.
- R2: The port divider modulus comes from `cfg_port_mode`: 0 = CC52_DIV, 1 = DS3_DIV, 2 = E3_DIV. With mode 3 the divider never strobes.
- R3: `cfg_port_sel` picks the port reference. With 0, `port_ref` is `rx_frame_ref` delayed by one cycle. With 1, it is the divided `tx_clk_en`. With 2, it is the divided `rx_clk_en`. With 3, `port_ref` stays low.
- R4: When `cfg_glb_ext`=1, `glb_ref` comes only from `ext_ref_in`. Each rising edge of that input gives one one-cycle strobe, seen after the second clock edge that samples the input high. Line-rate enables then have no effect on `glb_ref`.
- R5: When `cfg_glb_ext`=0 and `cfg_glb_sel`=3, `glb_ref` equals `port_ref`. Codes 4 to 7 hold `glb_ref` low.
- R6: `tx_ref` equals `glb_ref` when `cfg_tx_sel`=0 and equals `port_ref` when `cfg_tx_sel`=1.
- R7: `sec_tick` is high for one cycle, in the cycle after every SEC_DIV-th `glb_ref` strobe.
- R8: A change of `cfg_glb_ext` or `cfg_glb_sel` clears the global divider and the second counter. A change of `cfg_port_sel` or `cfg_port_mode` clears the port divider. After a clear, the next strobe needs a full modulus of enables.
- R9: While `rst` is high, all four outputs stay low whatever the enables do. After release, every count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_oc1_en | input | 1 | 51.84 MHz source enable pulse |
| src_ds3_en | input | 1 | DS3-rate source enable pulse |
| src_e3_en | input | 1 | E3-rate source enable pulse |
| tx_clk_en | input | 1 | Port transmit clock enable pulse |
| rx_clk_en | input | 1 | Port receive clock enable pulse |
| rx_frame_ref | input | 1 | Receive-path 8 kHz strobe |
| ext_ref_in | input | 1 | External 8 kHz reference level |
| cfg_glb_ext | input | 1 | Global reference taken from external input |
| cfg_glb_sel | input | 3 | Global source code |
| cfg_port_sel | input | 2 | Port source code |
| cfg_port_mode | input | 2 | Port line mode code |
| cfg_tx_sel | input | 1 | Transmit reference: 0 global, 1 port |
| glb_ref | output | 1 | Global 8 kHz strobe |
| port_ref | output | 1 | Port 8 kHz strobe |
| tx_ref | output | 1 | Transmit-path 8 kHz strobe |
| sec_tick | output | 1 | One-second strobe |

## Verification
The assertions assume three things about the inputs. Configuration changes only between bursts of source activity. Enables are single-cycle pulses on the system clock. The external reference is a slow level. So the count bound and the quiet cycle after a restart hold without exceptions for configuration changes made mid-count. The stimulus follows the same rules. It changes configuration only at idle cycles, followed by one idle cycle. It drives enables one cycle at a time. It holds the external input for several cycles per level. The sweeps use small moduli and pulse unselected sources in gap cycles to check that they are ignored.

// File: rtl/frame_ref_pkg.sv
package frame_ref_pkg;

    typedef enum logic [1:0] {
        LM_OC1  = 2'd0,
        LM_DS3  = 2'd1,
        LM_E3   = 2'd2,
        LM_NONE = 2'd3
    } line_mode_e;

    typedef enum logic [2:0] {
        GS_OC1  = 3'd0,
        GS_DS3  = 3'd1,
        GS_E3   = 3'd2,
        GS_PORT = 3'd3,
        GS_R4   = 3'd4,
        GS_R5   = 3'd5,
        GS_R6   = 3'd6,
        GS_R7   = 3'd7
    } glb_src_e;

    typedef enum logic [1:0] {
        PS_RXREF = 2'd0,
        PS_TXCLK = 2'd1,
        PS_RXCLK = 2'd2,
        PS_OFF   = 2'd3
    } port_src_e;

    typedef struct packed {
        logic     ext;
        glb_src_e sel;
    } glb_cfg_t;

    typedef struct packed {
        port_src_e  sel;
        line_mode_e mode;
    } port_cfg_t;

    // Modulus for a line mode; zero disables the divider.
    function automatic int unsigned mode_modulus(line_mode_e m, int unsigned d_oc1,
                                                 int unsigned d_ds3, int unsigned d_e3);
        case (m)
            LM_OC1:  return d_oc1;
            LM_DS3:  return d_ds3;
            LM_E3:   return d_e3;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         en,
    input  logic [W-1:0] modulus,
    output logic         strobe
);
    logic [W-1:0] cnt;
    logic         active;
    logic         last;

    assign active = (modulus != '0);
    assign last   = (cnt >= modulus - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= en && active && last;
            if (en && active)
                cnt <= last ? '0 : cnt + 1'b1;
        end
    end

    // R1: count never reaches the modulus while it is stable
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (active && !restart) |-> (cnt < modulus));
    // R1: a strobe is always caused by an enable one cycle earlier
    a_r1_strobe_needs_en: assert property (@(posedge clk) disable iff (rst)
        strobe |-> $past(en));
    // R8: a restart leaves the divider quiet and empty
    a_r8_restart_clears: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!strobe && cnt == '0));

endmodule

// File: rtl/ext_edge_sync.sv
module ext_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic strobe
);
    logic s1, s2, s3;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= level_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign strobe = s2 && !s3;

    // R4: one strobe per rising edge, never two cycles in a row
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);

endmodule

// File: rtl/frame_ref_gen.sv
module frame_ref_gen
    import frame_ref_pkg::*;
#(
    parameter int unsigned CC52_DIV = 6480,
    parameter int unsigned DS3_DIV  = 5592,
    parameter int unsigned E3_DIV   = 4296,
    parameter int unsigned SEC_DIV  = 8000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_oc1_en,
    input  logic       src_ds3_en,
    input  logic       src_e3_en,
    input  logic       tx_clk_en,
    input  logic       rx_clk_en,
    input  logic       rx_frame_ref,
    input  logic       ext_ref_in,
    input  logic       cfg_glb_ext,
    input  logic [2:0] cfg_glb_sel,
    input  logic [1:0] cfg_port_sel,
    input  logic [1:0] cfg_port_mode,
    input  logic       cfg_tx_sel,
    output logic       glb_ref,
    output logic       port_ref,
    output logic       tx_ref,
    output logic       sec_tick
);
    localparam int unsigned MOD_MAX = max3(CC52_DIV, DS3_DIV, E3_DIV);
    localparam int MOD_W = $clog2(MOD_MAX + 1);
    localparam int SEC_W = $clog2(SEC_DIV + 1);

    glb_cfg_t  gcfg, gcfg_q;
    port_cfg_t pcfg, pcfg_q;
    logic      glb_restart, port_restart;

    assign gcfg = '{ext: cfg_glb_ext, sel: glb_src_e'(cfg_glb_sel)};
    assign pcfg = '{sel: port_src_e'(cfg_port_sel), mode: line_mode_e'(cfg_port_mode)};

    always_ff @(posedge clk) begin
        gcfg_q <= gcfg;
        pcfg_q <= pcfg;
    end

    assign glb_restart  = (gcfg != gcfg_q);
    assign port_restart = (pcfg != pcfg_q);

    // Global divider source and modulus
    logic             g_en;
    logic [MOD_W-1:0] g_mod;
    logic             g_div;

    always_comb begin
        g_en  = 1'b0;
        g_mod = '0;
        case (gcfg.sel)
            GS_OC1: begin g_en = src_oc1_en; g_mod = MOD_W'(CC52_DIV); end
            GS_DS3: begin g_en = src_ds3_en; g_mod = MOD_W'(DS3_DIV);  end
            GS_E3:  begin g_en = src_e3_en;  g_mod = MOD_W'(E3_DIV);   end
            default: ;
        endcase
    end

    ref_divider #(.W(MOD_W)) u_glb_div (
        .clk(clk), .rst(rst), .restart(glb_restart),
        .en(g_en), .modulus(g_mod), .strobe(g_div)
    );

    // Port divider source and modulus
    logic             p_en;
    logic [MOD_W-1:0] p_mod;
    logic             p_div;

    always_comb begin
        case (pcfg.sel)
            PS_TXCLK: p_en = tx_clk_en;
            PS_RXCLK: p_en = rx_clk_en;
            default:  p_en = 1'b0;
        endcase
        p_mod = MOD_W'(mode_modulus(pcfg.mode, CC52_DIV, DS3_DIV, E3_DIV));
    end

    ref_divider #(.W(MOD_W)) u_port_div (
        .clk(clk), .rst(rst), .restart(port_restart),
        .en(p_en), .modulus(p_mod), .strobe(p_div)
    );

    // Receive-path reference, retimed once
    logic rx_ref_q;
    always_ff @(posedge clk) begin
        if (rst) rx_ref_q <= 1'b0;
        else     rx_ref_q <= rx_frame_ref;
    end

    logic ext_strobe;
    ext_edge_sync u_ext (
        .clk(clk), .rst(rst), .level_in(ext_ref_in), .strobe(ext_strobe)
    );

    always_comb begin
        case (pcfg.sel)
            PS_RXREF:          port_ref = rx_ref_q;
            PS_TXCLK, PS_RXCLK: port_ref = p_div;
            default:           port_ref = 1'b0;
        endcase
    end

    always_comb begin
        if (gcfg.ext) begin
            glb_ref = ext_strobe;
        end else begin
            case (gcfg.sel)
                GS_OC1, GS_DS3, GS_E3: glb_ref = g_div;
                GS_PORT:               glb_ref = port_ref;
                default:               glb_ref = 1'b0;
            endcase
        end
    end

    assign tx_ref = cfg_tx_sel ? port_ref : glb_ref;

    ref_divider #(.W(SEC_W)) u_sec_div (
        .clk(clk), .rst(rst), .restart(glb_restart),
        .en(glb_ref), .modulus(SEC_W'(SEC_DIV)), .strobe(sec_tick)
    );

    // R7: the second strobe only follows a global strobe
    a_r7_sec_after_glb: assert property (@(posedge clk) disable iff (rst)
        sec_tick |-> $past(glb_ref));

endmodule

// File: tb/tb_frame_ref_gen.sv
module tb_frame_ref_gen;
    localparam int CLK_P = 10;
    localparam int M_OC1 = 6;
    localparam int M_DS3 = 5;
    localparam int M_E3  = 4;
    localparam int M_SEC = 3;

    logic clk = 1'b0;
    logic rst;
    logic src_oc1_en, src_ds3_en, src_e3_en, tx_clk_en, rx_clk_en, rx_frame_ref, ext_ref_in;
    logic g_ext, t_sel;
    logic [2:0] g_sel;
    logic [1:0] p_sel, p_mode;
    logic glb_ref, port_ref, tx_ref, sec_tick;

    int checks = 0;
    int fails = 0;
    int gcnt = 0;
    bit sec_pend = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    frame_ref_gen #(.CC52_DIV(M_OC1), .DS3_DIV(M_DS3), .E3_DIV(M_E3), .SEC_DIV(M_SEC)) dut (
        .clk(clk), .rst(rst),
        .src_oc1_en(src_oc1_en), .src_ds3_en(src_ds3_en), .src_e3_en(src_e3_en),
        .tx_clk_en(tx_clk_en), .rx_clk_en(rx_clk_en), .rx_frame_ref(rx_frame_ref),
        .ext_ref_in(ext_ref_in),
        .cfg_glb_ext(g_ext), .cfg_glb_sel(g_sel), .cfg_port_sel(p_sel),
        .cfg_port_mode(p_mode), .cfg_tx_sel(t_sel),
        .glb_ref(glb_ref), .port_ref(port_ref), .tx_ref(tx_ref), .sec_tick(sec_tick)
    );

    task automatic chk(string req, string name, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, name, act, exp, $time);
        end
    endtask

    task automatic tick(bit eg, bit ep, string req);
        @(negedge clk);
        chk(req, "glb_ref", glb_ref, eg);
        chk(req, "port_ref", port_ref, ep);
        chk("R6", "tx_ref", tx_ref, t_sel ? ep : eg);
        chk("R7", "sec_tick", sec_tick, sec_pend);
        if (eg) begin
            gcnt++;
            sec_pend = (gcnt % M_SEC == 0);
        end else begin
            sec_pend = 1'b0;
        end
    endtask

    task automatic drive_srcs(int src, bit sel_v, bit oth_v);
        src_oc1_en   = (src == 0) ? sel_v : oth_v;
        src_ds3_en   = (src == 1) ? sel_v : oth_v;
        src_e3_en    = (src == 2) ? sel_v : oth_v;
        tx_clk_en    = (src == 3) ? sel_v : oth_v;
        rx_clk_en    = (src == 4) ? sel_v : oth_v;
        rx_frame_ref = (src == 5) ? sel_v : oth_v;
    endtask

    task automatic set_cfg(bit e, logic [2:0] gs, logic [1:0] ps, logic [1:0] pm, bit ts);
        if (e != g_ext || gs != g_sel) begin
            gcnt = 0;
            sec_pend = 1'b0;
        end
        g_ext = e; g_sel = gs; p_sel = ps; p_mode = pm; t_sel = ts;
        drive_srcs(-1, 1'b0, 1'b0);
        tick(1'b0, 1'b0, "R8");
    endtask

    // n pulses of source src; expected strobe after each m-th counting from start
    task automatic pulse_run(int src, int n, int m, int start, bit gapped,
                             bit to_g, bit to_p, string req);
        for (int i = 1; i <= n; i++) begin
            bit hit;
            if (gapped) begin
                drive_srcs(src, 1'b0, 1'b1);
                tick(1'b0, 1'b0, req);
            end
            drive_srcs(src, 1'b1, 1'b0);
            hit = ((start + i) % m == 0);
            tick(hit && to_g, hit && to_p, req);
        end
        drive_srcs(-1, 1'b0, 1'b0);
    endtask

    function automatic int mod_of(int code);
        return (code == 0) ? M_OC1 : (code == 1) ? M_DS3 : M_E3;
    endfunction

    initial begin
        #(CLK_P * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        g_ext = 1'b0; g_sel = 3'd0; p_sel = 2'd3; p_mode = 2'd3; t_sel = 1'b0;
        ext_ref_in = 1'b0;
        drive_srcs(0, 1'b1, 1'b0);
        // R9: outputs stay low under reset while a selected source pulses
        for (int i = 0; i < 10; i++) tick(1'b0, 1'b0, "R9");
        drive_srcs(-1, 1'b0, 1'b0);
        rst = 1'b0;
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, "R9");
        // R9: first strobe needs a full modulus after release
        pulse_run(0, M_OC1, M_OC1, 0, 1'b0, 1'b1, 1'b0, "R9");

        // R1: each global source with its own modulus, with and without distractors
        for (int gs = 0; gs < 3; gs++) begin
            for (int gp = 0; gp < 2; gp++) begin
                set_cfg(1'b0, 3'(gs), 2'd3, 2'd3, gp[0]);
                pulse_run(gs, 2 * mod_of(gs), mod_of(gs), 0, gp[0], 1'b1, 1'b0, "R1");
            end
        end

        // R2/R3: port divider per mode and clock source; R5 via global following port
        for (int pm = 0; pm < 4; pm++) begin
            for (int ps = 1; ps < 3; ps++) begin
                logic [2:0] gs;
                gs = (pm == 1) ? 3'd3 : 3'(4 + pm);
                set_cfg(1'b0, gs, 2'(ps), 2'(pm), ps == 2);
                if (pm == 3)
                    pulse_run(2 + ps, 12, 1, 0, 1'b1, 1'b0, 1'b0, "R2");
                else
                    pulse_run(2 + ps, 2 * mod_of(pm), mod_of(pm), 0, ps == 2,
                              gs == 3'd3, 1'b1, "R2");
            end
        end

        // R3/R5: receive-path strobe passes through with one cycle delay
        set_cfg(1'b0, 3'd3, 2'd0, 2'd1, 1'b1);
        pulse_run(5, 6, 1, 0, 1'b1, 1'b1, 1'b1, "R3");
        // R3: port source code 3 stays low
        set_cfg(1'b0, 3'd4, 2'd3, 2'd0, 1'b1);
        pulse_run(3, 8, 1, 0, 1'b1, 1'b0, 1'b0, "R3");
        pulse_run(5, 8, 1, 0, 1'b1, 1'b0, 1'b0, "R3");

        // R5: reserved global codes stay low
        for (int gs = 5; gs < 8; gs++) begin
            set_cfg(1'b0, 3'(gs), 2'd3, 2'd0, 1'b0);
            pulse_run(gs - 5, 12, 1, 0, 1'b1, 1'b0, 1'b0, "R5");
        end

        // R4: external reference, one strobe per rising edge; R7 after three
        set_cfg(1'b1, 3'd0, 2'd3, 2'd3, 1'b0);
        for (int k = 0; k < 4; k++) begin
            ext_ref_in = 1'b1;
            tick(1'b0, 1'b0, "R4");
            tick(1'b1, 1'b0, "R4");
            for (int j = 0; j < 3; j++) tick(1'b0, 1'b0, "R4");
            ext_ref_in = 1'b0;
            for (int j = 0; j < 4; j++) tick(1'b0, 1'b0, "R4");
        end
        // R4: line-rate enables ignored in external mode
        pulse_run(0, 12, 1, 0, 1'b1, 1'b0, 1'b0, "R4");

        // R8: global restart discards a partial count
        set_cfg(1'b0, 3'd0, 2'd3, 2'd3, 1'b0);
        pulse_run(0, M_OC1 - 2, M_OC1, 0, 1'b0, 1'b1, 1'b0, "R8");
        set_cfg(1'b0, 3'd1, 2'd3, 2'd3, 1'b0);
        set_cfg(1'b0, 3'd0, 2'd3, 2'd3, 1'b0);
        pulse_run(0, M_OC1, M_OC1, 0, 1'b0, 1'b1, 1'b0, "R8");
        // R8: port restart on mode change
        set_cfg(1'b0, 3'd4, 2'd1, 2'd1, 1'b1);
        pulse_run(3, 3, M_DS3, 0, 1'b0, 1'b0, 1'b1, "R8");
        set_cfg(1'b0, 3'd4, 2'd1, 2'd2, 1'b1);
        set_cfg(1'b0, 3'd4, 2'd1, 2'd1, 1'b1);
        pulse_run(3, M_DS3, M_DS3, 0, 1'b0, 1'b0, 1'b1, "R8");
        // R7: second counter restarts with the global configuration
        set_cfg(1'b0, 3'd2, 2'd3, 2'd3, 1'b0);
        pulse_run(2, 2 * M_E3, M_E3, 0, 1'b0, 1'b1, 1'b0, "R7");
        set_cfg(1'b0, 3'd1, 2'd3, 2'd3, 1'b0);
        pulse_run(1, 3 * M_DS3, M_DS3, 0, 1'b1, 1'b1, 1'b0, "R7");

        tick(1'b0, 1'b0, "R7");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule